// File: doc/BRIEF.md
# Secure security-control register bank

This block is the secure-side configuration window of a peripheral protection subsystem. It occupies a 4 KB, 32-bit register space and holds two small configuration fields. The first selects how security violations are answered. The second sets the non-secure-callable attribute bits. Each field is driven out continuously as a level signal.

It also stores two masks for each peripheral protection controller. The "non-secure" mask marks which ports of that controller belong to the non-secure world. The "secure-privileged" mask marks which of its ports need privileged secure access. The masks go straight to the access resolver logic. The controllers come in three groups: four expansion controllers on the high-performance bus, two internal controllers on the peripheral bus, and four expansion controllers on the peripheral bus. Inside each 16-byte group, address bits [3:2] select the controller.

Software reaches the bank over a simple request bus. Word writes are taken in a single cycle. Every request is answered one cycle later. Narrow writes are dropped without error. Narrow reads return the addressed byte lane. The top of the window holds a fixed identification table whose contents a build parameter selects. The bank also holds an enable word for bridge error interrupts, of which only the upper half is kept.

Top module: `sec_cfg_regbank`

## Requirements
- R1: After reset, both configuration outputs, every controller mask and the bridge enable word are zero, and reading them returns zero.
- R2: A word write to offset 0x010 stores bit 0 only. That bit appears on `resp_cfg_o` the cycle after the write, and reading 0x010 returns it.
- R3: A word write to offset 0x014 stores bits [1:0] only. Those bits appear on `callable_cfg_o` the cycle after the write, and reading 0x014 returns them.
- R4: Non-secure masks are written and read at these offsets: 0x060, 0x064, 0x068 and 0x06C for high-performance-bus expansion controllers 0 to 3; 0x070 and 0x074 for peripheral-bus internal controllers 0 and 1; and 0x080 to 0x08C for peripheral-bus expansion controllers 0 to 3. Address bits [3:2] give the controller. Controller k occupies bits [32k+31:32k] of its group's output.
- R5: Secure-privileged masks use the same arrangement at 0x0A0–0x0AC, 0x0B0/0x0B4 and 0x0C0–0x0CC. Reading 0x0A0–0x0AC returns the high-performance-bus expansion controllers' own values.
- R6: A written mask is ANDed with ones as wide as that controller's port count. The default counts are 16 for every expansion controller, 13 for internal controller 0 and 1 for internal controller 1. Bits above the count read as zero and drive zero.
- R7: A word write to 0x048 keeps only bits [31:16] of the bridge enable word. Reading 0x048 returns the kept bits, with bits [15:0] zero.
- R8: A write with size code 0 (byte) or 1 (halfword) changes no register, and a response is still returned. Size code 2 denotes a full word.
- R9: A read with size 0 or 1 returns the register word shifted right by 8 × addr[1:0], masked to 8 or 16 bits. A word read returns the whole register.
- R10: Reads return zero at 0x040, 0x050 and 0x090, at 0x024, 0x034 and 0x044, at 0x078 and 0x07C, at 0x0B8 and 0x0BC, and at every other undecoded offset.
- R11: Offsets 0xFD0 to 0xFFC, in steps of 4, read as the bytes 04,00,00,00,52,B8,0B,00,0D,F0,05,B1. When `ID_VARIANT` is 1, the entry at 0xFE8 reads 2B. Writes to these offsets have no effect.
- R12: Each request accepted with `req_valid` high produces `rsp_valid` high in the next cycle and in no other cycle. The response to a write carries `rsp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| resp_cfg_o | output | 1 | Violation response configuration |
| callable_cfg_o | output | 2 | Non-secure-callable configuration |
| ahbx_ns_o | output | 128 | Non-secure masks, high-performance-bus expansion controllers |
| apbi_ns_o | output | 64 | Non-secure masks, peripheral-bus internal controllers |
| apbx_ns_o | output | 128 | Non-secure masks, peripheral-bus expansion controllers |
| ahbx_pr_o | output | 128 | Secure-privileged masks, high-performance-bus expansion controllers |
| apbi_pr_o | output | 64 | Secure-privileged masks, peripheral-bus internal controllers |
| apbx_pr_o | output | 128 | Secure-privileged masks, peripheral-bus expansion controllers |

## Verification
The properties assume that `req_size` only takes the codes 0, 1 and 2. They also assume that `req_valid` may stay high on consecutive cycles with a new request each cycle, and that inputs never change around a clock edge. The bench holds each request for exactly one cycle and drives every input on the falling edge. It uses only the three defined size codes. It sweeps every word offset of the window with full writes, narrow writes and reads of every byte lane. A second instance with the identification variant selected shares the same stimulus.

// File: rtl/secbank_pkg.sv
package secbank_pkg;

    localparam int unsigned BANK_ADDR_W = 12;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned CNT_W       = 6;
    localparam int unsigned NUM_AHBX    = 4;
    localparam int unsigned NUM_APBI    = 2;
    localparam int unsigned NUM_APBX    = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        T_NONE, T_RESP, T_CALL, T_BRG,
        T_NS_AHBX, T_NS_APBI, T_NS_APBX,
        T_PR_AHBX, T_PR_APBI, T_PR_APBX,
        T_ID
    } target_e;

    typedef struct packed {
        target_e    tgt;
        logic [1:0] idx;
        logic [3:0] id_idx;
    } decode_t;

    function automatic logic [DATA_W-1:0] ones_upto(input int unsigned n);
        if (n >= DATA_W) return '1;
        return (DATA_W'(1) << n) - DATA_W'(1);
    endfunction

    function automatic logic [7:0] id_byte(input logic [3:0] i, input logic variant);
        case (i)
            4'd0:    return 8'h04;
            4'd4:    return 8'h52;
            4'd5:    return 8'hB8;
            4'd6:    return variant ? 8'h2B : 8'h0B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_pick(input logic [DATA_W-1:0] w,
                                                    input logic [1:0] lane,
                                                    input acc_size_e sz);
        logic [DATA_W-1:0] sh;
        sh = w >> {lane, 3'b000};
        case (sz)
            SZ_BYTE: return sh & 32'h0000_00FF;
            SZ_HALF: return sh & 32'h0000_FFFF;
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/secbank_decode.sv
module secbank_decode
    import secbank_pkg::*;
(
    input  logic [BANK_ADDR_W-1:2] word_addr,
    output decode_t                dec
);
    logic [BANK_ADDR_W-5:0] grp;
    logic [1:0]             idx;
    logic [1:0]             id_row;

    assign grp    = word_addr[BANK_ADDR_W-1:4];
    assign idx    = word_addr[3:2];
    assign id_row = grp[1:0] - 2'd1;

    always_comb begin
        dec.tgt    = T_NONE;
        dec.idx    = idx;
        dec.id_idx = {id_row, idx};
        case (grp)
            8'h01: begin
                if (idx == 2'd0) dec.tgt = T_RESP;
                if (idx == 2'd1) dec.tgt = T_CALL;
            end
            8'h04: if (idx == 2'd2) dec.tgt = T_BRG;
            8'h06: dec.tgt = T_NS_AHBX;
            8'h07: if (!idx[1]) dec.tgt = T_NS_APBI;
            8'h08: dec.tgt = T_NS_APBX;
            8'h0A: dec.tgt = T_PR_AHBX;
            8'h0B: if (!idx[1]) dec.tgt = T_PR_APBI;
            8'h0C: dec.tgt = T_PR_APBX;
            8'hFD, 8'hFE, 8'hFF: dec.tgt = T_ID;
            default: dec.tgt = T_NONE;
        endcase
    end
endmodule

// File: rtl/secbank_mask_group.sv
module secbank_mask_group
    import secbank_pkg::*;
#(
    parameter int unsigned           N    = 4,
    parameter logic [N*CNT_W-1:0]    CNTS = {N{6'd16}}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [N*DATA_W-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_ctrl
        localparam int unsigned PORTS = int'(CNTS[i*CNT_W +: CNT_W]);
        localparam logic [DATA_W-1:0] KEEP = ones_upto(PORTS);
        logic [DATA_W-1:0] mask_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= '0;
            end else if (wr_en && (wr_idx == 2'(i))) begin
                mask_q <= wr_data & KEEP;
            end
        end

        assign q_o[i*DATA_W +: DATA_W] = mask_q;
    end
endmodule

// File: rtl/sec_cfg_regbank.sv
module sec_cfg_regbank
    import secbank_pkg::*;
#(
    parameter int unsigned EXP_PORTS   = 16,
    parameter int unsigned APBI0_PORTS = 13,
    parameter int unsigned APBI1_PORTS = 1,
    parameter bit          ID_VARIANT  = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [BANK_ADDR_W-1:0]     req_addr,
    input  logic [1:0]                 req_size,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic                       resp_cfg_o,
    output logic [1:0]                 callable_cfg_o,
    output logic [NUM_AHBX*DATA_W-1:0] ahbx_ns_o,
    output logic [NUM_APBI*DATA_W-1:0] apbi_ns_o,
    output logic [NUM_APBX*DATA_W-1:0] apbx_ns_o,
    output logic [NUM_AHBX*DATA_W-1:0] ahbx_pr_o,
    output logic [NUM_APBI*DATA_W-1:0] apbi_pr_o,
    output logic [NUM_APBX*DATA_W-1:0] apbx_pr_o
);
    localparam logic [NUM_AHBX*CNT_W-1:0] AHBX_CNTS = {NUM_AHBX{CNT_W'(EXP_PORTS)}};
    localparam logic [NUM_APBX*CNT_W-1:0] APBX_CNTS = {NUM_APBX{CNT_W'(EXP_PORTS)}};
    localparam logic [NUM_APBI*CNT_W-1:0] APBI_CNTS = {CNT_W'(APBI1_PORTS), CNT_W'(APBI0_PORTS)};
    localparam int unsigned BRG_LO = DATA_W / 2;

    decode_t   dec;
    acc_size_e size_e;
    logic      wr_word;
    logic      resp_q;
    logic [1:0] call_q;
    logic [DATA_W-1:BRG_LO] brg_q;
    logic [DATA_W-1:0] word_val;

    assign size_e  = acc_size_e'(req_size);
    assign wr_word = req_valid && req_write && (size_e == SZ_WORD);

    secbank_decode u_dec (
        .word_addr (req_addr[BANK_ADDR_W-1:2]),
        .dec       (dec)
    );

    secbank_mask_group #(.N(NUM_AHBX), .CNTS(AHBX_CNTS)) u_ahbx_ns (
        .clk(clk), .rst(rst), .wr_en(wr_word && dec.tgt == T_NS_AHBX),
        .wr_idx(dec.idx), .wr_data(req_wdata), .q_o(ahbx_ns_o));
    secbank_mask_group #(.N(NUM_APBI), .CNTS(APBI_CNTS)) u_apbi_ns (
        .clk(clk), .rst(rst), .wr_en(wr_word && dec.tgt == T_NS_APBI),
        .wr_idx(dec.idx), .wr_data(req_wdata), .q_o(apbi_ns_o));
    secbank_mask_group #(.N(NUM_APBX), .CNTS(APBX_CNTS)) u_apbx_ns (
        .clk(clk), .rst(rst), .wr_en(wr_word && dec.tgt == T_NS_APBX),
        .wr_idx(dec.idx), .wr_data(req_wdata), .q_o(apbx_ns_o));
    secbank_mask_group #(.N(NUM_AHBX), .CNTS(AHBX_CNTS)) u_ahbx_pr (
        .clk(clk), .rst(rst), .wr_en(wr_word && dec.tgt == T_PR_AHBX),
        .wr_idx(dec.idx), .wr_data(req_wdata), .q_o(ahbx_pr_o));
    secbank_mask_group #(.N(NUM_APBI), .CNTS(APBI_CNTS)) u_apbi_pr (
        .clk(clk), .rst(rst), .wr_en(wr_word && dec.tgt == T_PR_APBI),
        .wr_idx(dec.idx), .wr_data(req_wdata), .q_o(apbi_pr_o));
    secbank_mask_group #(.N(NUM_APBX), .CNTS(APBX_CNTS)) u_apbx_pr (
        .clk(clk), .rst(rst), .wr_en(wr_word && dec.tgt == T_PR_APBX),
        .wr_idx(dec.idx), .wr_data(req_wdata), .q_o(apbx_pr_o));

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= 1'b0;
            call_q <= 2'b00;
            brg_q  <= '0;
        end else if (wr_word) begin
            case (dec.tgt)
                T_RESP:  resp_q <= req_wdata[0];
                T_CALL:  call_q <= req_wdata[1:0];
                T_BRG:   brg_q  <= req_wdata[DATA_W-1:BRG_LO];
                default: ;
            endcase
        end
    end

    assign resp_cfg_o     = resp_q;
    assign callable_cfg_o = call_q;

    always_comb begin
        case (dec.tgt)
            T_RESP:    word_val = {{(DATA_W-1){1'b0}}, resp_q};
            T_CALL:    word_val = {{(DATA_W-2){1'b0}}, call_q};
            T_BRG:     word_val = {brg_q, {BRG_LO{1'b0}}};
            T_NS_AHBX: word_val = ahbx_ns_o[dec.idx*DATA_W +: DATA_W];
            T_NS_APBI: word_val = apbi_ns_o[dec.idx[0]*DATA_W +: DATA_W];
            T_NS_APBX: word_val = apbx_ns_o[dec.idx*DATA_W +: DATA_W];
            T_PR_AHBX: word_val = ahbx_pr_o[dec.idx*DATA_W +: DATA_W];
            T_PR_APBI: word_val = apbi_pr_o[dec.idx[0]*DATA_W +: DATA_W];
            T_PR_APBX: word_val = apbx_pr_o[dec.idx*DATA_W +: DATA_W];
            T_ID:      word_val = {24'h0, id_byte(dec.id_idx, ID_VARIANT)};
            default:   word_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write)
                         ? lane_pick(word_val, req_addr[1:0], size_e) : '0;
        end
    end
endmodule

// File: rtl/secbank_checker.sv
module secbank_checker
    import secbank_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [BANK_ADDR_W-1:0]     req_addr,
    input logic [1:0]                 req_size,
    input logic [DATA_W-1:0]          req_wdata,
    input logic                       rsp_valid,
    input logic [DATA_W-1:0]          rsp_rdata,
    input logic                       resp_cfg_o,
    input logic [1:0]                 callable_cfg_o,
    input logic [NUM_AHBX*DATA_W-1:0] ahbx_ns_o,
    input logic [NUM_APBI*DATA_W-1:0] apbi_ns_o,
    input logic [NUM_APBX*DATA_W-1:0] apbx_ns_o,
    input logic [NUM_AHBX*DATA_W-1:0] ahbx_pr_o,
    input logic [NUM_APBI*DATA_W-1:0] apbi_pr_o,
    input logic [NUM_APBX*DATA_W-1:0] apbx_pr_o
);
    logic word_wr, narrow_wr;
    assign word_wr   = req_valid && req_write && (req_size == 2'd2);
    assign narrow_wr = req_valid && req_write && (req_size != 2'd2);

    assert_resp_write_R2: assert property (@(posedge clk) disable iff (rst)
        word_wr && req_addr == 12'h010 |=> resp_cfg_o == $past(req_wdata[0]));

    assert_call_write_R3: assert property (@(posedge clk) disable iff (rst)
        word_wr && req_addr == 12'h014 |=> callable_cfg_o == $past(req_wdata[1:0]));

    assert_narrow_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        narrow_wr |=> $stable(resp_cfg_o) && $stable(callable_cfg_o)
                   && $stable(ahbx_ns_o) && $stable(apbi_ns_o) && $stable(apbx_ns_o)
                   && $stable(ahbx_pr_o) && $stable(apbi_pr_o) && $stable(apbx_pr_o));

    assert_id_first_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write && req_size == 2'd2 && req_addr == 12'hFD0
        |=> rsp_rdata == 32'h0000_0004);

    assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_write_rsp_zero_R12: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write |=> rsp_rdata == '0);
endmodule

bind sec_cfg_regbank secbank_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .resp_cfg_o(resp_cfg_o),
    .callable_cfg_o(callable_cfg_o), .ahbx_ns_o(ahbx_ns_o), .apbi_ns_o(apbi_ns_o),
    .apbx_ns_o(apbx_ns_o), .ahbx_pr_o(ahbx_pr_o), .apbi_pr_o(apbi_pr_o),
    .apbx_pr_o(apbx_pr_o)
);

// File: tb/sec_cfg_regbank_tb.sv
module sec_cfg_regbank_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;

    logic rsp_valid, rsp_valid_v;
    logic [31:0] rsp_rdata, rsp_rdata_v;
    logic resp_cfg_o, resp_v;
    logic [1:0] callable_cfg_o, call_v;
    logic [127:0] ahbx_ns_o, apbx_ns_o, ahbx_pr_o, apbx_pr_o;
    logic [63:0]  apbi_ns_o, apbi_pr_o;
    logic [127:0] v_ahbx_ns, v_apbx_ns, v_ahbx_pr, v_apbx_pr;
    logic [63:0]  v_apbi_ns, v_apbi_pr;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sec_cfg_regbank u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .resp_cfg_o(resp_cfg_o),
        .callable_cfg_o(callable_cfg_o), .ahbx_ns_o(ahbx_ns_o), .apbi_ns_o(apbi_ns_o),
        .apbx_ns_o(apbx_ns_o), .ahbx_pr_o(ahbx_pr_o), .apbi_pr_o(apbi_pr_o),
        .apbx_pr_o(apbx_pr_o));

    sec_cfg_regbank #(.ID_VARIANT(1'b1)) u_dut_v (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid_v), .rsp_rdata(rsp_rdata_v), .resp_cfg_o(resp_v),
        .callable_cfg_o(call_v), .ahbx_ns_o(v_ahbx_ns), .apbi_ns_o(v_apbi_ns),
        .apbx_ns_o(v_apbx_ns), .ahbx_pr_o(v_ahbx_pr), .apbi_pr_o(v_apbi_pr),
        .apbx_pr_o(v_apbx_pr));

    // bench-side model
    logic [31:0] m_ahbx_ns [4], m_apbx_ns [4], m_ahbx_pr [4], m_apbx_pr [4];
    logic [31:0] m_apbi_ns [2], m_apbi_pr [2];
    logic        m_resp;
    logic [1:0]  m_call;
    logic [31:0] m_brg;
    logic [7:0]  id_tab [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h52, 8'hB8,
                                 8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_ahbx_ns[i] = 0; m_apbx_ns[i] = 0; m_ahbx_pr[i] = 0; m_apbx_pr[i] = 0;
        end
        for (int i = 0; i < 2; i++) begin
            m_apbi_ns[i] = 0; m_apbi_pr[i] = 0;
        end
        m_resp = 0; m_call = 0; m_brg = 0;
    endtask

    function automatic logic [31:0] apbi_keep(input int k);
        return (k == 0) ? 32'h0000_1FFF : 32'h0000_0001;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int g, k;
        g = int'(a[11:4]);
        k = int'(a[3:2]);
        case (g)
            8'h01: begin
                if (k == 0) m_resp = d[0];
                if (k == 1) m_call = d[1:0];
            end
            8'h04: if (k == 2) m_brg = d & 32'hFFFF_0000;
            8'h06: m_ahbx_ns[k] = d & 32'h0000_FFFF;
            8'h07: if (k < 2) m_apbi_ns[k] = d & apbi_keep(k);
            8'h08: m_apbx_ns[k] = d & 32'h0000_FFFF;
            8'h0A: m_ahbx_pr[k] = d & 32'h0000_FFFF;
            8'h0B: if (k < 2) m_apbi_pr[k] = d & apbi_keep(k);
            8'h0C: m_apbx_pr[k] = d & 32'h0000_FFFF;
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_word(input logic [11:0] a, input bit variant);
        int g, k;
        g = int'(a[11:4]);
        k = int'(a[3:2]);
        if (g >= 8'hFD) begin
            if (variant && (g - 8'hFD) * 4 + k == 6) return 32'h2B;
            return {24'h0, id_tab[(g - 8'hFD) * 4 + k]};
        end
        case (g)
            8'h01: return (k == 0) ? {31'h0, m_resp} : (k == 1) ? {30'h0, m_call} : 0;
            8'h04: return (k == 2) ? m_brg : 0;
            8'h06: return m_ahbx_ns[k];
            8'h07: return (k < 2) ? m_apbi_ns[k] : 0;
            8'h08: return m_apbx_ns[k];
            8'h0A: return m_ahbx_pr[k];
            8'h0B: return (k < 2) ? m_apbi_pr[k] : 0;
            8'h0C: return m_apbx_pr[k];
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        int g;
        g = int'(a[11:4]);
        if (g >= 8'hFD) return "R11";
        if (a == 12'h010) return "R2";
        if (a == 12'h014) return "R3";
        if (a == 12'h048) return "R7";
        if ((g == 8'h07 || g == 8'h0B) && a[3]) return "R10";
        if (g >= 8'h06 && g <= 8'h08) return "R4";
        if (g >= 8'h0A && g <= 8'h0C) return "R5";
        return "R10";
    endfunction

    // one request, held for one cycle; response sampled at the next falling edge
    task automatic do_req(input bit wr, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] d, output logic [31:0] rd, output logic [31:0] rdv);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd = rsp_rdata; rdv = rsp_rdata_v;
        check("R12", "rsp_valid after request", {127'h0, rsp_valid}, 128'h1);
        if (wr) check("R12", "write response data", {96'h0, rsp_rdata}, 128'h0);
    endtask

    task automatic check_outputs(input string tag);
        check(tag, "resp_cfg_o", {127'h0, resp_cfg_o}, {127'h0, m_resp});
        check(tag, "callable_cfg_o", {126'h0, callable_cfg_o}, {126'h0, m_call});
        check(tag, "ahbx_ns_o", ahbx_ns_o, {m_ahbx_ns[3], m_ahbx_ns[2], m_ahbx_ns[1], m_ahbx_ns[0]});
        check(tag, "apbi_ns_o", {64'h0, apbi_ns_o}, {64'h0, m_apbi_ns[1], m_apbi_ns[0]});
        check(tag, "apbx_ns_o", apbx_ns_o, {m_apbx_ns[3], m_apbx_ns[2], m_apbx_ns[1], m_apbx_ns[0]});
        check(tag, "ahbx_pr_o", ahbx_pr_o, {m_ahbx_pr[3], m_ahbx_pr[2], m_ahbx_pr[1], m_ahbx_pr[0]});
        check(tag, "apbi_pr_o", {64'h0, apbi_pr_o}, {64'h0, m_apbi_pr[1], m_apbi_pr[0]});
        check(tag, "apbx_pr_o", apbx_pr_o, {m_apbx_pr[3], m_apbx_pr[2], m_apbx_pr[1], m_apbx_pr[0]});
    endtask

    task automatic read_sweep(input string force_tag);
        logic [31:0] rd, rdv;
        for (int w = 0; w < 1024; w++) begin
            logic [11:0] a;
            string t;
            a = 12'(w * 4);
            t = (force_tag != "") ? force_tag : tag_of(a);
            do_req(1'b0, 2'd2, a, 32'h0, rd, rdv);
            check(t, $sformatf("word read %03h", a), {96'h0, rd}, {96'h0, model_word(a, 1'b0)});
            if (a >= 12'hFD0)
                check("R11", $sformatf("variant read %03h", a), {96'h0, rdv}, {96'h0, model_word(a, 1'b1)});
        end
    endtask

    task automatic write_sweep(input int mode);
        logic [31:0] rd, rdv, d;
        for (int w = 0; w < 1024; w++) begin
            logic [11:0] a;
            a = 12'(w * 4);
            d = (mode == 0) ? 32'hFFFF_FFFF : (32'(w) * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
            do_req(1'b1, 2'd2, a, d, rd, rdv);
            model_write(a, d);
        end
    endtask

    initial begin
        logic [31:0] rd, rdv;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state at ports and through reads
        check_outputs("R1");
        for (int w = 0; w < 64; w++) begin
            do_req(1'b0, 2'd2, 12'(w * 4), 32'h0, rd, rdv);
            check("R1", $sformatf("reset read %03h", w * 4), {96'h0, rd}, 128'h0);
        end

        // R12: no response on an idle cycle
        @(negedge clk);
        check("R12", "idle rsp_valid", {127'h0, rsp_valid}, 128'h0);

        // R6 / R7: all-ones writes everywhere, then read everything back
        write_sweep(0);
        check_outputs("R6");
        read_sweep("");

        // R2..R5, R11: pattern writes everywhere
        write_sweep(1);
        check_outputs("R4");
        read_sweep("");

        // R2 / R3 explicit values
        do_req(1'b1, 2'd2, 12'h010, 32'hFFFF_FFFE, rd, rdv); model_write(12'h010, 32'hFFFF_FFFE);
        do_req(1'b1, 2'd2, 12'h014, 32'h0000_0006, rd, rdv); model_write(12'h014, 32'h0000_0006);
        check_outputs("R2");
        do_req(1'b1, 2'd2, 12'h010, 32'h0000_0001, rd, rdv); model_write(12'h010, 32'h0000_0001);
        do_req(1'b1, 2'd2, 12'h014, 32'hFFFF_FFFD, rd, rdv); model_write(12'h014, 32'hFFFF_FFFD);
        check_outputs("R3");

        // R8: narrow writes at every byte of the decoded region change nothing
        for (int b = 0; b < 256; b++) begin
            for (int s = 0; s < 2; s++) begin
                do_req(1'b1, 2'(s), 12'(b), ~(32'(b) * 32'h0101_0101), rd, rdv);
            end
        end
        check_outputs("R8");
        read_sweep("R8");

        // R9: narrow reads of every lane in the decoded region and the ID table
        for (int b = 0; b < 4096; b++) begin
            if (b < 256 || b >= 12'hFD0) begin
                for (int s = 0; s < 2; s++) begin
                    logic [31:0] wv, exp;
                    wv  = model_word(12'(b & 12'hFFC), 1'b0);
                    exp = (wv >> (8 * (b % 4))) & ((s == 0) ? 32'hFF : 32'hFFFF);
                    do_req(1'b0, 2'(s), 12'(b), 32'h0, rd, rdv);
                    check("R9", $sformatf("narrow read %03h size %0d", b, s), {96'h0, rd}, {96'h0, exp});
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule